// File: doc/BRIEF.md
# Write-Back Data Cache with Software Line Control

This block is a set-associative, write-back, write-allocate data cache controller with 32-byte lines. Besides ordinary word loads and stores, it accepts commands that let software keep the cache coherent with DMA traffic without any snooping. A prefetch brings a line in only when it is absent. A forced fill always reloads a line from memory. A forced update writes a line back only when it is present and dirty, and it can select the line by address or by set/way index. Lock and unlock commands pin lines so that replacement never picks them.

The requester side takes one command at a time. A command is accepted when `req_valid_i` is high while `busy_o` is low. `busy_o` stays high until the command has finished, and load-type commands return a word through a one-cycle `resp_valid_o` pulse. On the memory side there is a blocking burst port that moves one whole line per request as four 64-bit beats. Replacement is round-robin over the unlocked ways of a set. When every way of the addressed set is locked, loads and stores go straight to memory without allocating.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset, `busy_o`, `resp_valid_o` and `mem_req_o` are low and every line is invalid, so the first access to any address misses.
- R2: A load (op 0) that hits returns the 32-bit word at `req_addr_i[4:2]` with no memory burst. A load that misses first fills the whole line with one read burst and then returns the word. In a burst, beat k carries word 2k in bits 31:0 and word 2k+1 in bits 63:32.
- R3: A store (op 1) writes `req_wdata_i` into the cached word and marks the line dirty without touching memory. A store that misses first allocates the line with one read burst.
- R4: A prefetch (op 2), or a load (op 0) with `req_dst_zero_i` high, fills the line only on a miss and never raises `resp_valid_o`.
- R5: A forced fill (op 3) reads the line from memory even on a hit and returns the requested word. If the line it hits is dirty, it writes that line back first.
- R6: A forced update by address (op 4) writes the line back only when it hits and is dirty, and it leaves the line clean. Its write data is discarded and it gives no response.
- R7: A forced update by index (op 5) targets set `req_addr_i[6:5]` and way `req_addr_i[1:0]`, and writes that entry back only when it is valid and dirty.
- R8: Lock (op 6) pins the line and fills it first on a miss. Unlock (op 7) releases a line that hits. A locked line is never chosen for replacement.
- R9: Each set keeps a round-robin pointer. The victim is the first unlocked way at or after the pointer, and the pointer then moves to the way after the victim. A dirty victim is written back before the fill.
- R10: When all ways of the set are locked, a load or forced fill reads the line and returns the word without installing it. A store reads the line, merges the word and writes the line back.
- R11: `busy_o` rises in the cycle after acceptance and stays high until completion. Requests presented while busy are ignored. `resp_valid_o` is a one-cycle pulse in the first idle cycle.
- R12: `mem_req_o` is raised only while busy, with a line-aligned address. Address and direction stay stable until four beats have each been acknowledged by `mem_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_op_i | input | 3 | Command code (0 load, 1 store, 2 prefetch, 3 forced fill, 4 update by address, 5 update by index, 6 lock, 7 unlock) |
| req_dst_zero_i | input | 1 | Load targets the zero register; the load becomes a prefetch |
| req_addr_i | input | 32 | Byte address, or set/way selector for op 5 |
| req_wdata_i | input | 32 | Store data |
| busy_o | output | 1 | Command in progress |
| resp_valid_o | output | 1 | Load data valid pulse |
| resp_data_o | output | 32 | Load data |
| mem_req_o | output | 1 | Burst request |
| mem_we_o | output | 1 | Burst is a write-back |
| mem_addr_o | output | 32 | Line-aligned burst address |
| mem_wdata_o | output | 64 | Write beat data |
| mem_rdata_i | input | 64 | Read beat data |
| mem_ready_i | input | 1 | Beat acknowledge |

## Verification
The hardest situation to reach from the ports is a set in which every way is locked. Only then does the uncached path run, with its read-merge-write for stores. The bench resets the cache, locks four lines that share set 0 and then aims loads and stores at a fifth line of that set. It counts read and write bursts to show that nothing was installed and that no locked line was evicted. Stale-data handling is exercised by changing the bench memory behind the cache, which mimics a DMA write, and then comparing a plain load with a forced fill.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int LINE_BYTES = 32;
  localparam int WORD_W     = 32;
  localparam int BEAT_W     = 64;
  localparam int BEATS      = LINE_BYTES * 8 / BEAT_W;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_PREF   = 3'd2,
    OP_FFILL  = 3'd3,
    OP_FUPD_A = 3'd4,
    OP_FUPD_I = 3'd5,
    OP_LOCK   = 3'd6,
    OP_UNLOCK = 3'd7
  } dc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WB, ST_FILL, ST_FIN
  } dc_state_e;
endpackage

// File: rtl/dcache_tag_match.sv
module dcache_tag_match #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 25
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]               tag_i,
  output logic                           hit_o,
  output logic [$clog2(NUM_WAYS)-1:0]    hit_way_o
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  logic [NUM_WAYS-1:0] match;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    hit_o     = |match;
    hit_way_o = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/dcache_victim_sel.sv
module dcache_victim_sel #(
  parameter int NUM_WAYS = 4
) (
  input  logic [NUM_WAYS-1:0]         lock_i,
  input  logic [$clog2(NUM_WAYS)-1:0] ptr_i,
  output logic                        found_o,
  output logic [$clog2(NUM_WAYS)-1:0] way_o
);
  localparam int WAY_W = $clog2(NUM_WAYS);

  // lowest distance from the pointer wins
  always_comb begin
    int idx;
    found_o = 1'b0;
    way_o   = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      idx = (int'(ptr_i) + i) % NUM_WAYS;
      if (!lock_i[idx]) begin
        found_o = 1'b1;
        way_o   = WAY_W'(idx);
      end
    end
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic              req_dst_zero_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [WORD_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BEAT_W-1:0] mem_wdata_o,
  input  logic [BEAT_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int BCNT_W = $clog2(BEATS);

  dc_state_e             state_q;
  dc_op_e                op_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [WORD_W-1:0]     wdata_q;
  logic [WAY_W-1:0]      way_q;
  logic                  uc_q, fill_after_q, resp_valid_q;
  logic [BCNT_W-1:0]     beat_q;
  logic [LINE_W-1:0]     buf_q;
  logic [WORD_W-1:0]     resp_data_q;

  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q   [NUM_SETS];
  logic [NUM_WAYS-1:0]            valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0]            dirty_q [NUM_SETS];
  logic [NUM_WAYS-1:0]            lock_q  [NUM_SETS];
  logic [WAY_W-1:0]               rr_q    [NUM_SETS];
  logic [LINE_W-1:0]              data_q  [NUM_SETS][NUM_WAYS];

  logic [IDX_W-1:0]  set_w;
  logic [TAG_W-1:0]  tag_w;
  logic [2:0]        woff;
  logic [WAY_W-1:0]  idx_way, hit_way, vic_way;
  logic              hit, vic_found, last_beat;
  logic [LINE_W-1:0] wb_line, fin_line;
  logic [ADDR_W-1:0] line_addr, wb_addr;

  assign set_w     = addr_q[OFF_W +: IDX_W];
  assign tag_w     = addr_q[ADDR_W-1 -: TAG_W];
  assign woff      = addr_q[4:2];
  assign idx_way   = addr_q[WAY_W-1:0];
  assign last_beat = (beat_q == BCNT_W'(BEATS - 1));

  dcache_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i   (tag_q[set_w]),
    .valid_i  (valid_q[set_w]),
    .tag_i    (tag_w),
    .hit_o    (hit),
    .hit_way_o(hit_way)
  );

  dcache_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_victim (
    .lock_i (lock_q[set_w]),
    .ptr_i  (rr_q[set_w]),
    .found_o(vic_found),
    .way_o  (vic_way)
  );

  always_comb begin
    fin_line = buf_q;
    if (op_q == OP_STORE) fin_line[{woff, 5'b0} +: WORD_W] = wdata_q;
  end

  assign wb_line   = uc_q ? buf_q : data_q[set_w][way_q];
  assign line_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wb_addr   = uc_q ? line_addr : {tag_q[set_w][way_q], set_w, {OFF_W{1'b0}}};

  assign busy_o       = (state_q != ST_IDLE);
  assign mem_req_o    = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o     = (state_q == ST_WB);
  assign mem_addr_o   = (state_q == ST_WB) ? wb_addr : line_addr;
  assign mem_wdata_o  = wb_line[{beat_q, 6'b0} +: BEAT_W];
  assign resp_valid_o = resp_valid_q;
  assign resp_data_o  = resp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_LOAD;
      addr_q       <= '0;
      wdata_q      <= '0;
      way_q        <= '0;
      uc_q         <= 1'b0;
      fill_after_q <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
      beat_q       <= '0;
      buf_q        <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        tag_q[s]   <= '0;
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        lock_q[s]  <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      resp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= (dc_op_e'(req_op_i) == OP_LOAD && req_dst_zero_i) ? OP_PREF
                                                                       : dc_op_e'(req_op_i);
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          uc_q    <= 1'b0;
          beat_q  <= '0;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          state_q <= ST_IDLE;
          if (op_q == OP_FUPD_A) begin
            if (hit && dirty_q[set_w][hit_way]) begin
              way_q <= hit_way; fill_after_q <= 1'b0; state_q <= ST_WB;
            end
          end else if (op_q == OP_FUPD_I) begin
            if (valid_q[set_w][idx_way] && dirty_q[set_w][idx_way]) begin
              way_q <= idx_way; fill_after_q <= 1'b0; state_q <= ST_WB;
            end
          end else if (op_q == OP_UNLOCK) begin
            if (hit) lock_q[set_w][hit_way] <= 1'b0;
          end else if (hit && op_q != OP_FFILL) begin
            if (op_q == OP_LOAD) begin
              resp_valid_q <= 1'b1;
              resp_data_q  <= data_q[set_w][hit_way][{woff, 5'b0} +: WORD_W];
            end
            if (op_q == OP_STORE) dirty_q[set_w][hit_way] <= 1'b1;
            if (op_q == OP_LOCK)  lock_q[set_w][hit_way]  <= 1'b1;
          end else if (hit) begin
            // forced fill on a hit: save dirty data, then reload in place
            way_q        <= hit_way;
            fill_after_q <= 1'b1;
            state_q      <= dirty_q[set_w][hit_way] ? ST_WB : ST_FILL;
          end else if (vic_found) begin
            way_q        <= vic_way;
            rr_q[set_w]  <= vic_way + WAY_W'(1);
            fill_after_q <= 1'b1;
            state_q      <= dirty_q[set_w][vic_way] ? ST_WB : ST_FILL;
          end else if (op_q == OP_LOAD || op_q == OP_STORE || op_q == OP_FFILL) begin
            uc_q    <= 1'b1;
            state_q <= ST_FILL;
          end
        end
        ST_WB: if (mem_ready_i) begin
          beat_q <= beat_q + BCNT_W'(1);
          if (last_beat) begin
            if (uc_q) state_q <= ST_IDLE;
            else begin
              dirty_q[set_w][way_q] <= 1'b0;
              state_q <= fill_after_q ? ST_FILL : ST_IDLE;
            end
          end
        end
        ST_FILL: if (mem_ready_i) begin
          buf_q[{beat_q, 6'b0} +: BEAT_W] <= mem_rdata_i;
          beat_q <= beat_q + BCNT_W'(1);
          if (last_beat) state_q <= ST_FIN;
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          if (uc_q && op_q == OP_STORE) begin
            buf_q   <= fin_line;
            state_q <= ST_WB;
          end else begin
            if (!uc_q) begin
              tag_q[set_w][way_q]   <= tag_w;
              valid_q[set_w][way_q] <= 1'b1;
              dirty_q[set_w][way_q] <= (op_q == OP_STORE);
              lock_q[set_w][way_q]  <= lock_q[set_w][way_q] | (op_q == OP_LOCK);
            end
            if (op_q == OP_LOAD || op_q == OP_FFILL) begin
              resp_valid_q <= 1'b1;
              resp_data_q  <= buf_q[{woff, 5'b0} +: WORD_W];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == ST_LOOKUP && op_q == OP_STORE && hit)
      data_q[set_w][hit_way][{woff, 5'b0} +: WORD_W] <= wdata_q;
    if (state_q == ST_FIN && !uc_q)
      data_q[set_w][way_q] <= fin_line;
  end
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        busy_o,
  input logic        resp_valid_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ready_i
);
  a_r12_mem_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  a_r12_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[4:0] == 5'd0));
  a_r12_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  a_r11_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
  a_r11_resp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !busy_o);
  a_r11_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
endmodule

bind dcache_ctrl dcache_ctrl_chk u_chk (.*);

// File: tb/dcache_ctrl_bench.sv
module dcache_ctrl_bench;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, PF = 3'd2, FF = 3'd3,
                         UA = 3'd4, UI = 3'd5, LK = 3'd6, UL = 3'd7;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_dz = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        busy_o, resp_valid_o, mem_req_o, mem_we_o;
  logic [31:0] resp_data_o, mem_addr_o;
  logic [63:0] mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b0;

  int tests = 0, fails = 0, proto_fails = 0, cycles = 0;
  int rd_bursts = 0, wr_bursts = 0, rdy_cnt = 0;
  logic [1:0]  beat_tb;
  logic [63:0] mem [1024];
  logic        got_v;
  logic [31:0] got_d;
  int          d_rd, d_wr;

  always #10 clk = ~clk;

  dcache_ctrl u_dcache_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_dst_zero_i(req_dz), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy_o), .resp_valid_o(resp_valid_o), .resp_data_o(resp_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i));

  function automatic logic [31:0] f(input int w);
    return 32'hC000_0000 | w;
  endfunction

  function automatic logic [31:0] memword(input logic [31:0] a);
    return a[2] ? mem[a[12:3]][63:32] : mem[a[12:3]][31:0];
  endfunction

  // behavioural memory: one beat per acknowledged cycle
  assign mem_rdata_i = mem[mem_addr_o[12:3] + 10'(beat_tb)];

  always @(negedge clk) begin
    rdy_cnt++;
    mem_ready_i <= (rdy_cnt % 3 != 2);
    if (rst_ni && ((mem_req_o && !busy_o) || (resp_valid_o && busy_o))) proto_fails++;
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) beat_tb <= '0;
    else if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) mem[mem_addr_o[12:3] + 10'(beat_tb)] <= mem_wdata_o;
      beat_tb <= beat_tb + 2'd1;
      if (beat_tb == 2'd3) begin
        if (mem_we_o) wr_bursts++;
        else rd_bursts++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic dz, input logic [31:0] a,
                        input logic [31:0] d);
    int r0, w0;
    r0 = rd_bursts; w0 = wr_bursts;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_dz = dz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy_o) @(negedge clk);
    got_v = resp_valid_o; got_d = resp_data_o;
    d_rd = rd_bursts - r0; d_wr = wr_bursts - w0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    tests++;
    if (proto_fails != 0) begin
      fails++;
      $display("FAIL R12: actual %0d protocol violations expected 0", proto_fails);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int r0;
    for (int k = 0; k < 1024; k++) mem[k] = {f(2 * k + 1), f(2 * k)};
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 resp_valid", 32'(resp_valid_o), 0);
    chk("R1 mem_req", 32'(mem_req_o), 0);
    rst_ni = 1'b1;

    // set 1 lines: 0x020 0x0A0 0x120 0x1A0 0x220
    do_req(LD, 0, 32'h024, 0);
    chk("R1 first access misses", 32'(d_rd), 1);
    chk("R2 miss data", got_d, f(9));
    chk("R2 miss resp", 32'(got_v), 1);
    do_req(LD, 0, 32'h028, 0);
    chk("R2 hit data", got_d, f(10));
    chk("R2 hit no burst", 32'(d_rd + d_wr), 0);
    do_req(ST, 0, 32'h024, 32'h1234_5678);
    chk("R3 store hit no burst", 32'(d_rd + d_wr), 0);
    do_req(LD, 0, 32'h024, 0);
    chk("R3 store readback", got_d, 32'h1234_5678);
    chk("R3 memory untouched", memword(32'h024), f(9));
    do_req(ST, 0, 32'h0A4, 32'hAAAA_0001);
    chk("R3 store miss allocates", 32'(d_rd), 1);
    do_req(LD, 0, 32'h0A0, 0);
    chk("R3 rest of line", got_d, f(32'h28));
    do_req(LD, 0, 32'h0A4, 0);
    chk("R3 merged word", got_d, 32'hAAAA_0001);

    do_req(PF, 0, 32'h120, 0);
    chk("R4 prefetch fills", 32'(d_rd), 1);
    chk("R4 prefetch no resp", 32'(got_v), 0);
    do_req(PF, 0, 32'h124, 0);
    chk("R4 prefetch hit no burst", 32'(d_rd), 0);
    do_req(LD, 1, 32'h1A0, 0);
    chk("R4 zero-dest load fills", 32'(d_rd), 1);
    chk("R4 zero-dest load no resp", 32'(got_v), 0);
    do_req(LD, 0, 32'h1A0, 0);
    chk("R4 line present", 32'(d_rd), 0);

    // set 1 full, pointer at way 0 (0x020, dirty)
    do_req(LD, 0, 32'h220, 0);
    chk("R9 dirty victim written", 32'(d_wr), 1);
    chk("R9 then filled", 32'(d_rd), 1);
    chk("R9 victim data in memory", memword(32'h024), 32'h1234_5678);
    do_req(LD, 0, 32'h0A0, 0);
    chk("R9 way 1 kept", 32'(d_rd), 0);
    do_req(LD, 0, 32'h020, 0);
    chk("R9 next victim way 1", 32'(d_wr), 1);
    chk("R9 reload data", got_d, f(8));
    chk("R9 way 1 data in memory", memword(32'h0A4), 32'hAAAA_0001);

    do_req(ST, 0, 32'h128, 32'h5555_0000);
    do_req(UA, 0, 32'h128, 32'hFFFF_FFFF);
    chk("R6 dirty written back", 32'(d_wr), 1);
    chk("R6 no response", 32'(got_v), 0);
    chk("R6 store data discarded", memword(32'h128), 32'h5555_0000);
    do_req(UA, 0, 32'h128, 0);
    chk("R6 clean after update", 32'(d_wr), 0);
    do_req(UA, 0, 32'h320, 0);
    chk("R6 miss no burst", 32'(d_wr + d_rd), 0);

    mem[32'h1A4 >> 3][63:32] = 32'hD0D0_0001;  // DMA write behind the cache
    do_req(LD, 0, 32'h1A4, 0);
    chk("R5 plain load stale", got_d, f(32'h69));
    do_req(FF, 0, 32'h1A4, 0);
    chk("R5 forced fill refetches", got_d, 32'hD0D0_0001);
    chk("R5 clean hit no write", 32'(d_wr), 0);
    chk("R5 hit still reads", 32'(d_rd), 1);
    do_req(ST, 0, 32'h1A8, 32'hBEEF_0002);
    do_req(FF, 0, 32'h1A8, 0);
    chk("R5 dirty hit written first", 32'(d_wr), 1);
    chk("R5 dirty data kept", got_d, 32'hBEEF_0002);

    // set 1: w0 0x220 w1 0x020 w2 0x120 w3 0x1A0
    do_req(ST, 0, 32'h12C, 32'h9999_0006);
    do_req(UI, 0, 32'h023, 0);
    chk("R7 clean entry no burst", 32'(d_wr), 0);
    do_req(UI, 0, 32'h022, 0);
    chk("R7 indexed write-back", 32'(d_wr), 1);
    chk("R7 indexed data", memword(32'h12C), 32'h9999_0006);
    do_req(ST, 0, 32'h22C, 32'h7777_0003);
    do_req(ST, 0, 32'h030, 32'h8888_0004);
    r0 = wr_bursts;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) do_req(UI, 0, 32'((s << 5) | w), 0);
    chk("R7 sweep count", 32'(wr_bursts - r0), 2);
    chk("R7 sweep data a", memword(32'h22C), 32'h7777_0003);
    chk("R7 sweep data b", memword(32'h030), 32'h8888_0004);
    r0 = wr_bursts;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) do_req(UI, 0, 32'((s << 5) | w), 0);
    chk("R7 second sweep idle", 32'(wr_bursts - r0), 0);

    // requests while busy are dropped
    @(negedge clk);
    req_valid = 1'b1; req_op = LD; req_dz = 1'b0; req_addr = 32'h2A4;
    @(negedge clk);
    chk("R11 busy after accept", 32'(busy_o), 1);
    req_op = ST; req_addr = 32'h224; req_wdata = 32'hBAD0_BAD0;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    while (busy_o) @(negedge clk);
    chk("R11 response pulse", 32'(resp_valid_o), 1);
    chk("R11 load data", resp_data_o, f(32'hA9));
    @(negedge clk);
    chk("R11 pulse one cycle", 32'(resp_valid_o), 0);
    do_req(LD, 0, 32'h224, 0);
    chk("R11 busy store ignored", got_d, f(32'h89));

    // locking in set 0
    do_reset();
    do_req(LK, 0, 32'h000, 0);
    chk("R8 lock miss fills", 32'(d_rd), 1);
    do_req(LK, 0, 32'h080, 0);
    do_req(LK, 0, 32'h100, 0);
    do_req(LK, 0, 32'h180, 0);
    do_req(LD, 0, 32'h204, 0);
    chk("R10 uncached load data", got_d, f(32'h81));
    chk("R10 uncached load read", 32'(d_rd), 1);
    do_req(LD, 0, 32'h204, 0);
    chk("R10 not installed", 32'(d_rd), 1);
    do_req(LD, 0, 32'h004, 0);
    chk("R8 locked line kept", 32'(d_rd), 0);
    chk("R8 locked data", got_d, f(1));
    do_req(ST, 0, 32'h208, 32'hCAFE_0005);
    chk("R10 uncached store read", 32'(d_rd), 1);
    chk("R10 uncached store write", 32'(d_wr), 1);
    chk("R10 uncached store data", memword(32'h208), 32'hCAFE_0005);
    do_req(UL, 0, 32'h080, 0);
    chk("R8 unlock no burst", 32'(d_rd + d_wr), 0);
    do_req(LD, 0, 32'h200, 0);
    chk("R8 unlocked way reused", 32'(d_rd), 1);
    do_req(LD, 0, 32'h200, 0);
    chk("R8 installed", 32'(d_rd), 0);
    do_req(LD, 0, 32'h084, 0);
    chk("R8 unlocked line evicted", 32'(d_rd), 1);
    do_req(LD, 0, 32'h104, 0);
    chk("R8 other locks kept", 32'(d_rd), 0);

    finish_run();
  end
endmodule